// File: doc/BRIEF.md
# Multi-Antenna Maximal-Ratio Combiner with BPSK Slicer

This block merges up to four antenna branches into one hard BPSK decision per data symbol. Each branch brings a complex received sample and a complex channel-gain estimate, both in signed 12.8 fixed point. The estimate refers to a symbol that arrived a fixed number of symbol periods earlier, so the block holds the received samples back until they meet the matching estimate. For every enabled branch it forms the real part of the conjugated gain times the sample with one multiply-add. It then sums the branches and rounds the total to 8 fractional bits. The sign of the result gives the bit.

A slot holds one pilot followed by data symbols. The caller marks each accepted symbol with its position inside the slot. Only data positions produce a decision. Clearing branch-enable bits shrinks the combiner. With a single branch left it acts as a plain one-antenna detector.

Top module: `mrc_bpsk_combiner`

## Requirements
- R1: While reset is high and after it falls, `dec_valid` and `dec_bit` are 0 until the first decision is produced.
- R2: Each branch term equals gain_re·rx_re + gain_im·rx_im, all four operands signed 12.8 values. A nonzero imaginary gain changes the decision exactly as the formula predicts.
- R3: The combined value is the exact sum of the terms of the branches whose `br_en` bit is 1. A branch whose bit is 0 adds zero, whatever its data. Four full-scale branches of either sign never wrap.
- R4: The received samples used for a decision are those accepted 42 symbol periods earlier. Symbol periods are counted in `sym_valid` strobes, not clock cycles. The gains and enables used are those accepted with the current symbol.
- R5: The first 42 symbols accepted after reset produce no decision.
- R6: `sym_pos` = 0 (pilot) and `sym_pos` ≥ 7 produce no decision. Positions 1 to 6 each produce exactly one decision.
- R7: The full-precision sum (16 fractional bits) is rounded to 8 fractional bits by adding 2^-9 and truncating toward minus infinity. A rounded value ≥ 0, including exactly 0, gives `dec_bit` = 0. A negative value gives 1.
- R8: A decision shows `dec_valid` = 1 for one cycle, registered on the fourth rising edge counted from the edge that accepts the symbol. `dec_bit` changes only when `dec_valid` is 1.
- R9: With exactly one enable bit set, the decision is the sign of that branch's term alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Accepts one symbol this cycle |
| sym_pos | input | 3 | Position of the symbol in its slot, 0 = pilot |
| br_en | input | 4 | Per-branch enable |
| rx_re | input | 80 | Received real parts, 20 bits per branch, branch 0 in the low bits |
| rx_im | input | 80 | Received imaginary parts, same packing |
| gain_re | input | 80 | Gain estimate real parts, same packing |
| gain_im | input | 80 | Gain estimate imaginary parts, same packing |
| dec_valid | output | 1 | Decision strobe |
| dec_bit | output | 1 | Decided bit (1 for a negative combined value) |

## Verification
An off-by-one in the sample delay or its pointer wrap gives wrong bits as soon as the data after the priming window diverges from the data one symbol away, which is within a few decisions of random stimulus. A miscounted fill state or a wrong position decode shows at once as a strobe during priming or on a pilot, or as a missing strobe four edges after a data symbol. Rounding and guard-bit faults hide under random data, so directed sums of −128, −129, 0 and full scale expose them on the first affected decision.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int unsigned PILOT_POS = 0;

  function automatic logic is_data_pos(input int unsigned pos, input int unsigned slot_len);
    return (pos != PILOT_POS) && (pos < slot_len);
  endfunction
endpackage

// File: rtl/rx_delay_line.sv
module rx_delay_line #(
  parameter int unsigned DW    = 160,
  parameter int unsigned DEPTH = 42,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          primed
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [CW-1:0] fill;

  // read-before-write on one port: the word read left DEPTH advances ago
  always_ff @(posedge clk) begin
    if (adv) begin
      dout     <= mem[ptr];
      mem[ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      fill <= '0;
    end else if (adv) begin
      ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  assign primed = (fill == CW'(DEPTH));
endmodule

// File: rtl/branch_madd.sv
module branch_madd #(
  parameter int unsigned W  = 20,
  localparam int unsigned TW = 2 * W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 br_on,
  input  logic signed [W-1:0]  g_re,
  input  logic signed [W-1:0]  g_im,
  input  logic signed [W-1:0]  y_re,
  input  logic signed [W-1:0]  y_im,
  output logic signed [TW-1:0] term
);
  logic signed [2*W-1:0] p_re, p_im;

  assign p_re = g_re * y_re;
  assign p_im = g_im * y_im;

  always_ff @(posedge clk) begin
    if (rst)        term <= '0;
    else if (br_on) term <= TW'(p_re) + TW'(p_im);
    else            term <= '0;
  end
endmodule

// File: rtl/term_adder_tree.sv
module term_adder_tree #(
  parameter int unsigned NB  = 4,
  parameter int unsigned IW  = 41,
  localparam int unsigned LV   = (NB > 1) ? $clog2(NB) : 0,
  localparam int unsigned PADN = 1 << LV,
  localparam int unsigned OW   = IW + LV
) (
  input  logic [NB*IW-1:0]     terms,
  output logic signed [OW-1:0] sum
);
  logic signed [OW-1:0] node [2*PADN];

  // heap layout: leaves at PADN..2*PADN-1, root at 1
  always_comb begin
    node[0] = '0;
    for (int i = 0; i < PADN; i++) begin
      if (i < NB) node[PADN + i] = OW'($signed(terms[i*IW +: IW]));
      else        node[PADN + i] = '0;
    end
    for (int k = PADN - 1; k >= 1; k--) begin
      node[k] = node[2*k] + node[2*k + 1];
    end
  end

  assign sum = (PADN == 1) ? node[1] : node[1];
endmodule

// File: rtl/decision_slicer.sv
module decision_slicer #(
  parameter int unsigned SW = 43,
  parameter int unsigned FB = 8,
  localparam int unsigned RW = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic signed [SW-1:0] sum,
  output logic                 dec_valid,
  output logic                 dec_bit
);
  logic signed [RW-1:0] biased, rounded;

  assign biased  = RW'(sum) + (RW'(1) <<< (FB - 1));
  assign rounded = biased >>> FB;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= valid_in;
      if (valid_in) dec_bit <= rounded[RW-1];
    end
  end
endmodule

// File: rtl/mrc_bpsk_combiner.sv
module mrc_bpsk_combiner #(
  parameter int unsigned NB        = 4,
  parameter int unsigned IB        = 12,
  parameter int unsigned FB        = 8,
  parameter int unsigned SLOT_LEN  = 7,
  parameter int unsigned ALIGN_DLY = 42,
  parameter int unsigned POS_W     = $clog2(SLOT_LEN + 1),
  localparam int unsigned W        = IB + FB,
  localparam int unsigned TW       = 2 * W + 1,
  localparam int unsigned SW       = TW + ((NB > 1) ? $clog2(NB) : 0),
  localparam int unsigned DW       = NB * 2 * W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  logic [POS_W-1:0]  sym_pos,
  input  logic [NB-1:0]     br_en,
  input  logic [NB*W-1:0]   rx_re,
  input  logic [NB*W-1:0]   rx_im,
  input  logic [NB*W-1:0]   gain_re,
  input  logic [NB*W-1:0]   gain_im,
  output logic              dec_valid,
  output logic              dec_bit
);
  import mrc_pkg::*;

  logic [DW-1:0]   dly_in, dly_out;
  logic            primed;
  logic            v1, v2, v3;
  logic [NB-1:0]   en1;
  logic [NB*W-1:0] g1_re, g1_im;
  logic [NB*TW-1:0] terms;
  logic signed [SW-1:0] sum_c, sum3;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_pack
      assign dly_in[(2*b)*W   +: W] = rx_re[b*W +: W];
      assign dly_in[(2*b+1)*W +: W] = rx_im[b*W +: W];
    end
  endgenerate

  rx_delay_line #(.DW(DW), .DEPTH(ALIGN_DLY)) u_dly (
    .clk(clk), .rst(rst), .adv(sym_valid), .din(dly_in),
    .dout(dly_out), .primed(primed)
  );

  // stage 1: capture current estimates next to the delayed samples
  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      en1   <= '0;
      g1_re <= '0;
      g1_im <= '0;
    end else begin
      v1 <= sym_valid && primed && is_data_pos(int'(sym_pos), SLOT_LEN);
      if (sym_valid) begin
        en1   <= br_en;
        g1_re <= gain_re;
        g1_im <= gain_im;
      end
    end
  end

  // stage 2: one multiply-add per branch
  generate
    for (b = 0; b < NB; b++) begin : g_branch
      branch_madd #(.W(W)) u_madd (
        .clk(clk), .rst(rst), .br_on(en1[b]),
        .g_re($signed(g1_re[b*W +: W])),
        .g_im($signed(g1_im[b*W +: W])),
        .y_re($signed(dly_out[(2*b)*W +: W])),
        .y_im($signed(dly_out[(2*b+1)*W +: W])),
        .term(terms[b*TW +: TW])
      );
    end
  endgenerate

  // stage 3: branch sum with guard bits
  term_adder_tree #(.NB(NB), .IW(TW)) u_tree (
    .terms(terms), .sum(sum_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v2   <= 1'b0;
      v3   <= 1'b0;
      sum3 <= '0;
    end else begin
      v2   <= v1;
      v3   <= v2;
      sum3 <= sum_c;
    end
  end

  // stage 4: round and slice
  decision_slicer #(.SW(SW), .FB(FB)) u_slice (
    .clk(clk), .rst(rst), .valid_in(v3), .sum(sum3),
    .dec_valid(dec_valid), .dec_bit(dec_bit)
  );
endmodule

// File: rtl/mrc_combiner_checker.sv
module mrc_combiner_checker #(
  parameter int unsigned SLOT_LEN  = 7,
  parameter int unsigned ALIGN_DLY = 42,
  parameter int unsigned POS_W     = 3,
  localparam int unsigned CW       = $clog2(ALIGN_DLY + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [POS_W-1:0] sym_pos,
  input logic             dec_valid,
  input logic             dec_bit
);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (sym_valid && seen <= CW'(ALIGN_DLY)) seen <= seen + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dec_valid && !dec_bit);

  p_no_early_decision_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (seen > CW'(ALIGN_DLY)));

  p_data_position_only_r6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ($past(sym_valid, 4) && ($past(sym_pos, 4) != '0)
                   && (int'($past(sym_pos, 4)) < SLOT_LEN)));

  p_bit_held_r8: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> $stable(dec_bit));
endmodule

bind mrc_bpsk_combiner mrc_combiner_checker #(
  .SLOT_LEN(SLOT_LEN), .ALIGN_DLY(ALIGN_DLY), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_pos(sym_pos),
  .dec_valid(dec_valid), .dec_bit(dec_bit)
);

// File: tb/tb_mrc_bpsk_combiner.sv
module tb_mrc_bpsk_combiner;
  localparam int NB = 4, W = 20, DLY = 42, SLOT = 7, LAT = 4, HMAX = 4096;

  logic clk = 0, rst = 1, sym_valid = 0;
  logic [2:0] sym_pos = '0;
  logic [NB-1:0] br_en = '0;
  logic [NB*W-1:0] rx_re = '0, rx_im = '0, gain_re = '0, gain_im = '0;
  logic dec_valid, dec_bit;

  always #4 clk = ~clk;

  mrc_bpsk_combiner dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_pos(sym_pos), .br_en(br_en),
    .rx_re(rx_re), .rx_im(rx_im), .gain_re(gain_re), .gain_im(gain_im),
    .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  int checks = 0, errors = 0, cyc = 0, sym_n = 0, n_out = 0, n_exp = 0, slot_pos = 0;
  bit done = 0;
  int yr_h[NB][HMAX], yi_h[NB][HMAX];
  int cur_gr[NB], cur_gi[NB], cur_yr[NB], cur_yi[NB];
  int due_q[$];
  bit exp_q[$];
  string tag_q[$];

  function automatic int s20(input int v);
    logic [19:0] r = v[19:0];
    return int'($signed(r));
  endfunction

  function automatic int rnd_val(input int mode);
    if (mode == 0) return s20(int'($urandom));
    return int'($urandom_range(0, 600)) - 300;
  endfunction

  task automatic check_bit(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (dec_valid) n_out++;
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      if (!dec_valid) begin
        checks++; errors++;
        $display("FAIL R8: actual dec_valid 0 expected 1 (cycle %0d, %s)", cyc, tag_q[0]);
      end else check_bit(tag_q[0], dec_bit, exp_q[0]);
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end else if (dec_valid && !rst) begin
      checks++; errors++;
      $display("FAIL R6: actual dec_valid 1 expected 0 (cycle %0d)", cyc);
    end
  endtask

  task automatic idle();
    sym_valid = 0;
    tick();
  endtask

  // drive one symbol from the cur_* arrays, then advance one cycle
  task automatic put_sym(input int pos, input logic [NB-1:0] en, input string tag);
    longint s, r;
    sym_valid = 1;
    sym_pos   = 3'(pos);
    br_en     = en;
    for (int b = 0; b < NB; b++) begin
      rx_re[b*W +: W]   = W'(cur_yr[b]);
      rx_im[b*W +: W]   = W'(cur_yi[b]);
      gain_re[b*W +: W] = W'(cur_gr[b]);
      gain_im[b*W +: W] = W'(cur_gi[b]);
      yr_h[b][sym_n] = cur_yr[b];
      yi_h[b][sym_n] = cur_yi[b];
    end
    if (sym_n >= DLY && pos >= 1 && pos < SLOT) begin
      s = 0;
      for (int b = 0; b < NB; b++)
        if (en[b]) s += longint'(cur_gr[b]) * yr_h[b][sym_n-DLY]
                      + longint'(cur_gi[b]) * yi_h[b][sym_n-DLY];
      r = (s + 128) >>> 8;
      due_q.push_back(cyc + LAT);
      exp_q.push_back(r < 0);
      tag_q.push_back(tag);
      n_exp++;
    end
    sym_n++;
    tick();
    sym_valid = 0;
  endtask

  task automatic put_next(input logic [NB-1:0] en, input string tag);
    put_sym(slot_pos, en, tag);
    slot_pos = (slot_pos + 1) % SLOT;
  endtask

  task automatic rand_all(input int mode);
    for (int b = 0; b < NB; b++) begin
      cur_gr[b] = rnd_val(mode); cur_gi[b] = rnd_val(mode);
      cur_yr[b] = rnd_val(mode); cur_yi[b] = rnd_val(mode);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) tick();
    check_bit("R1 dec_valid in reset", dec_valid, 1'b0);
    rst = 0;
    tick();
    check_bit("R1 dec_valid after reset", dec_valid, 1'b0);
    check_bit("R1 dec_bit after reset", dec_bit, 1'b0);

    // R5: priming window
    for (int i = 0; i < DLY; i++) begin
      rand_all(0);
      put_next(4'hF, "R5");
      if ($urandom_range(0, 3) == 0) idle();
    end
    repeat (LAT + 1) idle();
    checks++;
    if (n_out != 0) begin
      errors++;
      $display("FAIL R5: actual %0d decisions expected 0 during priming", n_out);
    end

    // R4/R3/R9: random traffic with gaps, varied enables and magnitudes
    for (int i = 0; i < 700; i++) begin
      logic [NB-1:0] en = 4'($urandom);
      int cnt = $countones(en);
      rand_all(int'($urandom_range(0, 1)));
      if (i % 97 == 50) put_sym(7, en, "R6");
      put_next(en, (cnt == 1) ? "R9" : ((i % 2) ? "R4" : "R3"));
      if ($urandom_range(0, 2) == 0) idle();
    end

    // R3: full-scale operands, four branches of each sign
    for (int b = 0; b < NB; b++) begin
      cur_yr[b] = -524288; cur_yi[b] = -524288;
      cur_gr[b] = -524288; cur_gi[b] = -524288;
    end
    for (int i = 0; i < DLY + 10; i++) begin
      if (i >= DLY && (i % 2 == 1))
        for (int b = 0; b < NB; b++) begin cur_gr[b] = 524287; cur_gi[b] = 524287; end
      else
        for (int b = 0; b < NB; b++) begin cur_gr[b] = -524288; cur_gi[b] = -524288; end
      put_next(4'hF, "R3");
    end

    // R7/R2/R3: branch 0 delayed sample fixed at (-1, 3)
    for (int b = 0; b < NB; b++) begin
      cur_yr[b] = (b == 0) ? -1 : s20(int'($urandom));
      cur_yi[b] = (b == 0) ? 3  : s20(int'($urandom));
      cur_gr[b] = s20(int'($urandom)); cur_gi[b] = s20(int'($urandom));
    end
    for (int i = 0; i < DLY; i++) put_next(4'h1, "R9");
    slot_pos = 1;
    begin
      int gr_l[8] = '{128, 129, 0, 127, 0, 0, 256, 129};
      int gi_l[8] = '{0,   0,   0, 0, -43, -42, 0,  0};
      for (int k = 0; k < 8; k++) begin
        cur_gr[0] = gr_l[k]; cur_gi[0] = gi_l[k];
        if (slot_pos == 0) slot_pos = 1;
        put_next(4'h1, (k == 4 || k == 5) ? "R2" : ((k == 7) ? "R3" : "R7"));
      end
    end

    repeat (LAT + 3) idle();
    checks++;
    if (n_out != n_exp || due_q.size() != 0) begin
      errors++;
      $display("FAIL R6: actual %0d decisions expected %0d", n_out, n_exp);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule